// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital heart of a successive-approximation analog-to-digital converter. A start request, taken while the block is idle, clears an internal approximation register and begins a binary search. One clock period is spent on each bit, from the top of the code down. In each period the block drives a trial code to an external DAC and reads back one comparator line. That line tells it whether the DAC output for the trial code lies above the analog input. When the last bit is settled, the finished code is presented as the result, the busy flag drops and a single-cycle end-of-conversion pulse is issued.

Two conversion lengths are offered. They are chosen at the moment a start is accepted: a full 12-bit search, or a shortened 8-bit search that settles only the upper bits. A conversion in flight cannot be cut short or restarted. The block exposes no data handshake: the result is plain status-style data qualified by the busy flag and the end-of-conversion pulse. Since there is no back-pressure, a consumer that misses the pulse can still read the held result at any time while the block is idle. The analog DAC, comparator, reference and any sample-and-hold stay outside; the comparator reaches the block as an ordinary synchronous digital input.

Top module: `sar_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves busy_o low, eoc_o low, result_o equal to zero and trial_code_o equal to zero.
- R2: A start_i level seen high at a rising edge while idle is accepted: busy_o is high from that edge on, and the first trial code is 12'h800 (only bit 11 set, all other bits cleared).
- R3: During a conversion the trial bit moves down by one position per clock, from bit 11 towards bit 0, and every bit below the current trial bit reads zero in trial_code_o.
- R4: When cmp_above_i is high in a trial cycle, the trial bit is cleared for the rest of the conversion; when it is low, the bit stays set. A conversion therefore yields the largest code whose DAC level is not above the input.
- R5: With short_i low at acceptance, busy_o stays high for exactly 12 clock cycles and all 12 result bits are resolved.
- R6: With short_i high at acceptance, busy_o stays high for exactly 8 clock cycles, bits 11 to 4 are resolved and result bits 3 to 0 read zero.
- R7: short_i is captured only when a start is accepted; changing it during a conversion alters neither the length nor the result.
- R8: start_i asserted while busy_o is high is ignored: the running conversion is neither stopped nor restarted, and its length and result are unchanged.
- R9: eoc_o is high for exactly one cycle, namely the first cycle in which busy_o is low again after a conversion; result_o then shows the new code.
- R10: result_o reads zero while busy_o is high, and holds the last conversion's code unchanged while idle.
- R11: trial_code_o reads zero whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, accepted only while idle |
| short_i | input | 1 | Length select sampled at acceptance: 1 = 8-bit search, 0 = 12-bit search |
| cmp_above_i | input | 1 | Comparator result: 1 when the DAC level for trial_code_o is above the analog input |
| trial_code_o | output | 12 | Code driven to the external DAC during a conversion, zero when idle |
| busy_o | output | 1 | High for the whole conversion |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | 12 | Last completed code, forced to zero during a conversion |

## Verification
Some properties are checked on every clock edge. The one-hot walk of the lowest trial bit, the zero result and idle trial code, and the MSB-only first trial are among them. So are the pairing of the busy fall with a single eoc pulse and the legal conversion lengths of 8 and 12 cycles, where an 8-cycle run must leave the low nibble clear. Only the bench scenarios can show that the search lands on the right code for a given input. They also show that start requests and length changes made mid-conversion leave both the length and the code untouched, and that the result persists through idle time.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int SHORT_BITS = 8,
  localparam int IDX_W     = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             short_sel,
  output logic             busy,
  output logic             accept,
  output logic             finish,
  output logic             short_q,
  output logic [IDX_W-1:0] bit_idx,
  output logic             eoc
);
  localparam logic [IDX_W-1:0] MSB_IDX    = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(RES_W - SHORT_BITS);

  sar_state_e       state_q;
  logic [IDX_W-1:0] last_idx;

  assign busy     = (state_q == ST_RUN);
  assign accept   = (state_q == ST_IDLE) && start;
  assign last_idx = short_q ? SHORT_LAST : '0;
  assign finish   = busy && (bit_idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_idx <= '0;
      short_q <= 1'b0;
      eoc     <= 1'b0;
    end else begin
      eoc <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            bit_idx <= MSB_IDX;
            short_q <= short_sel;
          end
        end
        ST_RUN: begin
          if (finish) begin
            state_q <= ST_IDLE;
            eoc     <= 1'b1;
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES_W      = 12,
  parameter int SHORT_BITS = 8,
  localparam int IDX_W     = $clog2(RES_W),
  localparam int DROP_BITS = RES_W - SHORT_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             finish,
  input  logic             short_q,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_above,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result_q
);
  logic [RES_W-1:0] approx_q;
  logic [RES_W-1:0] bit_mask;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] keep_mask;

  assign bit_mask = {{(RES_W-1){1'b0}}, 1'b1} << bit_idx;
  assign trial    = approx_q | bit_mask;
  assign decided  = cmp_above ? approx_q : trial;

  for (genvar g = 0; g < RES_W; g++) begin : g_keep
    if (g < DROP_BITS) begin : g_low
      assign keep_mask[g] = ~short_q;
    end else begin : g_high
      assign keep_mask[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      approx_q <= '0;
      result_q <= '0;
    end else begin
      if (clear) begin
        approx_q <= '0;
      end else if (step) begin
        approx_q <= decided;
      end
      if (finish) begin
        result_q <= decided & keep_mask;
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W      = 12,
  parameter int SHORT_BITS = 8,
  localparam int IDX_W     = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_above_i,
  output logic [RES_W-1:0] trial_code_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic [RES_W-1:0] result_o
);
  logic             busy;
  logic             accept;
  logic             finish;
  logic             short_q;
  logic [IDX_W-1:0] bit_idx;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] result_q;

  sar_ctrl #(.RES_W(RES_W), .SHORT_BITS(SHORT_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .short_sel (short_i),
    .busy      (busy),
    .accept    (accept),
    .finish    (finish),
    .short_q   (short_q),
    .bit_idx   (bit_idx),
    .eoc       (eoc_o)
  );

  // the register stage only advances while a conversion runs (gated step)
  sar_reg #(.RES_W(RES_W), .SHORT_BITS(SHORT_BITS)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .step      (busy),
    .finish    (finish),
    .short_q   (short_q),
    .bit_idx   (bit_idx),
    .cmp_above (cmp_above_i),
    .trial     (trial),
    .result_q  (result_q)
  );

  assign busy_o       = busy;
  assign trial_code_o = busy ? trial : '0;
  assign result_o     = busy ? '0 : result_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W      = 12,
  parameter int SHORT_BITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             eoc_o,
  input logic [RES_W-1:0] trial_code_o,
  input logic [RES_W-1:0] result_o
);
  localparam int CNT_W = $clog2(RES_W + 2);
  localparam int DROP  = RES_W - SHORT_BITS;

  logic [CNT_W-1:0] run_cnt;
  logic [RES_W-1:0] low_now;
  logic [RES_W-1:0] low_prev;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  assign low_now = trial_code_o & (~trial_code_o + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) low_prev <= '0;
    else     low_prev <= low_now;
  end

  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> trial_code_o == {1'b1, {(RES_W-1){1'b0}}});

  // R3
  bit_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> (low_now == (low_prev >> 1)));

  // R9
  eoc_follows_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> eoc_o);

  // R9
  eoc_single_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o);

  // R10
  result_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> result_o == '0);

  // R11
  idle_trial_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> trial_code_o == '0);

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (run_cnt == CNT_W'(RES_W) || run_cnt == CNT_W'(SHORT_BITS)));

  // R6
  short_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && run_cnt == CNT_W'(SHORT_BITS)) |-> result_o[DROP-1:0] == '0);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .SHORT_BITS(SHORT_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy_o       (busy_o),
  .eoc_o        (eoc_o),
  .trial_code_o (trial_code_o),
  .result_o     (result_o)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        short_i = 1'b0;
  logic        cmp_above_i;
  logic [11:0] trial_code_o;
  logic        busy_o;
  logic        eoc_o;
  logic [11:0] result_o;
  logic [11:0] target = 12'h000;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  // comparator model: DAC level above the held input
  assign cmp_above_i = (trial_code_o > target);

  sar_seq u_dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .short_i      (short_i),
    .cmp_above_i  (cmp_above_i),
    .trial_code_o (trial_code_o),
    .busy_o       (busy_o),
    .eoc_o        (eoc_o),
    .result_o     (result_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R1 busy", 32'(busy_o), 0);
    check(eoc_o == 1'b0, "R1 eoc", 32'(eoc_o), 0);
    check(result_o == 12'h0, "R1 result", 32'(result_o), 0);
    check(trial_code_o == 12'h0, "R11 idle trial", 32'(trial_code_o), 0);
  endtask

  // one conversion; optional mid-run start pulse (R8) and length flip (R7)
  task automatic t_convert(input logic [11:0] tgt, input bit shrt, input bit mid_start, input bit flip_len);
    logic [11:0] exp_res;
    int exp_len;
    int k;
    target  = tgt;
    short_i = shrt;
    exp_len = shrt ? 8 : 12;
    exp_res = shrt ? (tgt & 12'hFF0) : tgt;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after accept", 32'(busy_o), 1);
    check(trial_code_o == 12'h800, "R2 first trial", 32'(trial_code_o), 32'h800);
    k = 0;
    while (busy_o && k < 20) begin
      int idx = 11 - k;
      if (idx >= 0) begin
        check(trial_code_o[idx] == 1'b1 && (trial_code_o & ((12'h1 << idx) - 12'h1)) == 12'h0,
              "R3 trial bit position", 32'(trial_code_o), 32'(12'h1 << idx));
        check((trial_code_o >> (idx + 1)) == (exp_res >> (idx + 1)),
              "R4 settled upper bits", 32'(trial_code_o >> (idx + 1)), 32'(exp_res >> (idx + 1)));
      end
      check(result_o == 12'h0, "R10 result hidden while busy", 32'(result_o), 0);
      if (mid_start && k == 3) start_i = 1'b1;
      if (mid_start && k == 5) start_i = 1'b0;
      if (flip_len && k == 2) short_i = ~shrt;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    check(k == exp_len, shrt ? "R6 short length" : "R5 long length", 32'(k), 32'(exp_len));
    check(eoc_o == 1'b1, "R9 eoc at completion", 32'(eoc_o), 1);
    check(result_o == exp_res, shrt ? "R6 short result" : "R5 long result", 32'(result_o), 32'(exp_res));
    if (flip_len) check(result_o == exp_res, "R7 length latched", 32'(result_o), 32'(exp_res));
    if (mid_start) check(k == exp_len, "R8 start ignored while busy", 32'(k), 32'(exp_len));
    check(trial_code_o == 12'h0, "R11 trial zero when idle", 32'(trial_code_o), 0);
    @(negedge clk);
    check(eoc_o == 1'b0, "R9 eoc single cycle", 32'(eoc_o), 0);
    check(busy_o == 1'b0, "R8 no restart", 32'(busy_o), 0);
  endtask

  task automatic t_hold(input int cycles);
    logic [11:0] held = result_o;
    target = ~target;
    repeat (cycles) @(negedge clk);
    check(result_o == held, "R10 result held while idle", 32'(result_o), 32'(held));
    check(busy_o == 1'b0, "R10 stays idle", 32'(busy_o), 0);
  endtask

  initial begin
    t_reset();
    t_convert(12'hA5C, 1'b0, 1'b0, 1'b0);
    t_hold(6);
    t_convert(12'h000, 1'b0, 1'b0, 1'b0);
    t_convert(12'hFFF, 1'b0, 1'b0, 1'b0);
    t_convert(12'h7FF, 1'b0, 1'b0, 1'b0);
    t_convert(12'h800, 1'b1, 1'b0, 1'b0);
    t_convert(12'h00F, 1'b1, 1'b0, 1'b0);
    t_convert(12'h3C7, 1'b0, 1'b1, 1'b0);
    t_convert(12'hB6D, 1'b1, 1'b1, 1'b0);
    t_convert(12'h5A9, 1'b0, 1'b0, 1'b1);
    t_convert(12'hE31, 1'b1, 1'b0, 1'b1);
    t_hold(4);
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule